// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a 16-bit position count for a rotary shaft that carries an incremental encoder with two phase signals, A and B, offset by a quarter period. Each phase input comes from off chip and is not tied to the system clock. Each input passes through a two-flop synchroniser. The block then compares the synchronised pair against the pair it sampled on the previous cycle. A change on either phase moves the count by one step. The direction comes from which phase moved and the level the other phase held at that moment. The count therefore advances four times per encoder line, and it tracks shaft displacement in both directions.

The count wraps in both directions. Each wrap produces a one-cycle carry pulse: one pulse for wrapping up and a separate pulse for wrapping down. A second instance can form the upper half of a 32-bit count. To do this, set its cascade select high and feed the lower half's two carry pulses into its external up and down strobe inputs.

A synchronous load port writes a preset position, and a load takes priority over any count event in the same cycle. An enable input freezes the count without losing track of the phase state. If both phases appear to change in the same sample, no count step is taken and an error pulse is raised instead.

Top module: `qenc_counter`

## Requirements
- R1: While reset is held and after its release, the count reads 0x0000 and the overflow, underflow and error pulses are low.
- R2: The count increases by one when A rises with B low, when B rises with A high, when A falls with B high, or when B falls with A low. Taking the phase pair as {A,B}, the forward order of states is 00, 10, 11, 01, then back to 00.
- R3: The count decreases by one when A falls with B low, when B falls with A high, when A rises with B high, or when B rises with A low.
- R4: When both synchronised phases change between consecutive samples, the count keeps its value and the error output is high for exactly one cycle.
- R5: After a phase input changes, the count shows the result after the third rising clock edge and not earlier. The three edges are two synchroniser stages and the count register.
- R6: Counting up from 0xFFFF gives 0x0000, and the overflow output is high for exactly that one cycle.
- R7: Counting down from 0x0000 gives 0xFFFF, and the underflow output is high for exactly that one cycle.
- R8: While the enable is low, phase changes do not alter the count. Phase changes made while disabled cause no count step when the enable is raised again.
- R9: A load sets the count to the load value at the next edge. This holds even when a count event falls in the same cycle, and in that case no overflow or underflow pulse is produced.
- R10: With cascade select high, the phase inputs are ignored. Each external up strobe adds one and each external down strobe subtracts one. Two such instances joined by their carry pulses form a 32-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| countEn | input | 1 | Count enable |
| cascadeSel | input | 1 | 1: count external strobes; 0: count phase edges |
| extUp | input | 1 | External increment strobe (lower half's overflow) |
| extDn | input | 1 | External decrement strobe (lower half's underflow) |
| loadEn | input | 1 | Synchronous preset strobe |
| loadValue | input | WIDTH | Preset value |
| countValue | output | WIDTH | Current position count |
| ovfPulse | output | 1 | One-cycle pulse on up-wrap |
| unfPulse | output | 1 | One-cycle pulse on down-wrap |
| errPulse | output | 1 | One-cycle pulse when both phases changed in one sample |

## Verification
A stale previous-sample register or a misdecoded case in the transition table shows as a count off by one, or moving the wrong way, three edges after the phase change. An exhaustive sweep covers every start state against every possible transition and exposes either fault at once. A wrong synchroniser depth shows as the count moving one edge early or late. A missed wrap detection shows as a missing or stretched carry pulse, and in the cascaded pair the upper half then stays unchanged on the following cycle.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  // Strobes handed from the phase decoder to the count register
  typedef struct packed {
    logic inc;   // step count up
    logic dec;   // step count down
    logic bad;   // both phases moved in one sample
  } qencStrobe_t;

endpackage

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseA,
  input  logic        phaseB,
  input  logic        countEn,
  input  logic        cascadeSel,
  input  logic        extUp,
  input  logic        extDn,
  output qencStrobe_t stb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][1:0] syncPipe;
  logic [1:0] curAB;
  logic [1:0] prevAB;
  logic phaseMode;
  logic tblInc, tblDec, tblBad;

  assign curAB = syncPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      prevAB   <= '0;
    end else begin
      syncPipe[0] <= {phaseA, phaseB};
      for (int i = 1; i < SYNC_STAGES; i++) begin
        syncPipe[i] <= syncPipe[i-1];
      end
      prevAB <= curAB;
    end
  end

  // Transition table on {prevA, prevB, curA, curB}
  always_comb begin
    tblInc = 1'b0;
    tblDec = 1'b0;
    tblBad = 1'b0;
    unique case ({prevAB, curAB})
      4'b00_10: tblInc = 1'b1;  // A up, B low
      4'b10_11: tblInc = 1'b1;  // B up, A high
      4'b11_01: tblInc = 1'b1;  // A down, B high
      4'b01_00: tblInc = 1'b1;  // B down, A low
      4'b00_01: tblDec = 1'b1;  // B up, A low
      4'b01_11: tblDec = 1'b1;  // A up, B high
      4'b11_10: tblDec = 1'b1;  // B down, A high
      4'b10_00: tblDec = 1'b1;  // A down, B low
      4'b00_11, 4'b11_00,
      4'b01_10, 4'b10_01: tblBad = 1'b1;
      default: ;
    endcase
  end

  assign phaseMode = countEn && !cascadeSel;

  always_comb begin
    stb.inc = 1'b0;
    stb.dec = 1'b0;
    stb.bad = 1'b0;
    if (phaseMode) begin
      stb.inc = tblInc;
      stb.dec = tblDec;
      stb.bad = tblBad;
    end else if (countEn) begin
      stb.inc = extUp && !extDn;
      stb.dec = extDn && !extUp;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.inc, stb.dec, stb.bad}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |-> !(stb.inc || stb.dec || stb.bad));

endmodule

// File: rtl/qenc_dp.sv
module qenc_dp
  import qenc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qencStrobe_t      stb,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] countValue,
  output logic             ovfPulse,
  output logic             unfPulse,
  output logic             errPulse
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countValue <= '0;
      ovfPulse   <= 1'b0;
      unfPulse   <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
      errPulse <= stb.bad;
      if (loadEn) begin
        countValue <= loadValue;
      end else if (stb.inc) begin
        countValue <= countValue + ONE;
        ovfPulse   <= (countValue == TOP);
      end else if (stb.dec) begin
        countValue <= countValue - ONE;
        unfPulse   <= (countValue == '0);
      end
    end
  end

  // R6
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (countValue == '0) && ($past(countValue) == TOP));

  // R7
  unf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (countValue == TOP) && ($past(countValue) == '0));

  // R9
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadEn) |-> (countValue == $past(loadValue)) && !ovfPulse && !unfPulse);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.inc || stb.dec || loadEn) |-> $stable(countValue));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !$past(loadEn)) |-> $stable(countValue));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             countEn,
  input  logic             cascadeSel,
  input  logic             extUp,
  input  logic             extDn,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] countValue,
  output logic             ovfPulse,
  output logic             unfPulse,
  output logic             errPulse
);

  qencStrobe_t stb;

  qenc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseA     (phaseA),
    .phaseB     (phaseB),
    .countEn    (countEn),
    .cascadeSel (cascadeSel),
    .extUp      (extUp),
    .extDn      (extDn),
    .stb        (stb)
  );

  qenc_dp #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .loadEn     (loadEn),
    .loadValue  (loadValue),
    .countValue (countValue),
    .ovfPulse   (ovfPulse),
    .unfPulse   (unfPulse),
    .errPulse   (errPulse)
  );

endmodule

// File: tb/tb_qenc_counter.sv
module tb_qenc_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b0, phaseB = 1'b0;
  logic        countEn = 1'b1;
  logic        loadEn = 1'b0;
  logic [15:0] loadValue = '0;
  logic [15:0] countLo, countHi;
  logic        ovfLo, unfLo, errLo, ovfHi, unfHi, errHi;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  qenc_counter dut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .countEn(countEn), .cascadeSel(1'b0), .extUp(1'b0), .extDn(1'b0),
    .loadEn(loadEn), .loadValue(loadValue),
    .countValue(countLo), .ovfPulse(ovfLo), .unfPulse(unfLo), .errPulse(errLo)
  );

  // Upper half of a 32-bit count; sees the same phases, which it must ignore
  qenc_counter upper (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .countEn(1'b1), .cascadeSel(1'b1), .extUp(ovfLo), .extDn(unfLo),
    .loadEn(1'b0), .loadValue(16'h0000),
    .countValue(countHi), .ovfPulse(ovfHi), .unfPulse(unfHi), .errPulse(errHi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int pos(input logic a, input logic b);
    return a ? (b ? 2 : 1) : (b ? 3 : 0);
  endfunction

  // Drive new phases at a falling edge, sample after the third rising edge
  task automatic step(input logic a, input logic b);
    @(negedge clk);
    phaseA = a;
    phaseB = b;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stepFwd();
    logic a, b;
    case (pos(phaseA, phaseB))
      0: begin a = 1; b = 0; end
      1: begin a = 1; b = 1; end
      2: begin a = 0; b = 1; end
      default: begin a = 0; b = 0; end
    endcase
    step(a, b);
  endtask

  task automatic stepBack();
    logic a, b;
    case (pos(phaseA, phaseB))
      0: begin a = 0; b = 1; end
      1: begin a = 0; b = 0; end
      2: begin a = 1; b = 0; end
      default: begin a = 1; b = 1; end
    endcase
    step(a, b);
  endtask

  task automatic doLoad(input logic [15:0] v);
    @(negedge clk);
    loadEn = 1'b1;
    loadValue = v;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 count", {16'h0, countLo}, 32'h0);
    check("R1 flags", {29'h0, ovfLo, unfLo, errLo}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {countHi, countLo}, 32'h0);

    // R5 latency: nothing after two edges, step after the third
    @(negedge clk);
    phaseA = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 not before third edge", {16'h0, countLo}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R5 at third edge", {16'h0, countLo}, 32'h1);

    // Exhaustive sweep: each start state x each transition (R2, R3, R4)
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 3; t++) begin
        logic na, nb;
        int d;
        while (pos(phaseA, phaseB) != s) stepFwd();
        doLoad(16'h1234);
        na = (t != 1) ? ~phaseA : phaseA;
        nb = (t != 0) ? ~phaseB : phaseB;
        d = (pos(na, nb) - pos(phaseA, phaseB) + 4) % 4;
        step(na, nb);
        if (d == 1) begin
          check("R2 increment", {16'h0, countLo}, 32'h1235);
          check("R2 no error", {31'h0, errLo}, 32'h0);
        end else if (d == 3) begin
          check("R3 decrement", {16'h0, countLo}, 32'h1233);
          check("R3 no error", {31'h0, errLo}, 32'h0);
        end else begin
          check("R4 count held", {16'h0, countLo}, 32'h1234);
          check("R4 error high", {31'h0, errLo}, 32'h1);
          @(negedge clk);
          check("R4 error one cycle", {31'h0, errLo}, 32'h0);
        end
        check("R10 phases ignored in cascade", {16'h0, countHi}, 32'h0);
      end
    end

    // R6 overflow and carry into the upper half
    doLoad(16'hFFFF);
    stepFwd();
    check("R6 wrap to zero", {16'h0, countLo}, 32'h0);
    check("R6 ovf high", {31'h0, ovfLo}, 32'h1);
    @(negedge clk);
    check("R6 ovf one cycle", {31'h0, ovfLo}, 32'h0);
    check("R10 32-bit up carry", {countHi, countLo}, 32'h0001_0000);

    // R7 underflow and borrow from the upper half
    stepBack();
    check("R7 wrap to max", {16'h0, countLo}, 32'hFFFF);
    check("R7 unf high", {31'h0, unfLo}, 32'h1);
    @(negedge clk);
    check("R7 unf one cycle", {31'h0, unfLo}, 32'h0);
    check("R10 32-bit down borrow", {countHi, countLo}, 32'h0000_FFFF);

    // R8 enable low freezes count; no stale step on re-enable
    doLoad(16'h0100);
    countEn = 1'b0;
    for (int k = 0; k < 3; k++) stepFwd();
    check("R8 held while disabled", {16'h0, countLo}, 32'h0100);
    countEn = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 no step on re-enable", {16'h0, countLo}, 32'h0100);
    stepBack();
    check("R8 counts again", {16'h0, countLo}, 32'h00FF);

    // R9 load wins over a coincident wrapping increment
    doLoad(16'hFFFF);
    @(negedge clk);
    loadEn = 1'b1;
    loadValue = 16'h4000;
    stepFwd();
    check("R9 load value", {16'h0, countLo}, 32'h4000);
    check("R9 no ovf", {31'h0, ovfLo}, 32'h0);
    loadEn = 1'b0;
    @(negedge clk);
    check("R9 upper untouched", {16'h0, countHi}, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule